// File: doc/BRIEF.md
# Stack Frame Push/Pop Sequencer

This block builds and tears down a subroutine stack frame over several cycles. It can save any subset of the twelve callee-saved registers r20 to r31 to memory, or restore such a subset, one 32-bit word per memory access. In both directions it also moves the stack pointer by an extra local-frame size.

A caller pulses `start_i` with the operation inputs:

- the direction (`dispose_i`);
- the register selection, delivered as a 1-bit upper field and an 11-bit lower field;
- the 5-bit frame-size count;
- a 5-bit jump-register index;
- the current stack pointer.

The block then reads or writes the register file through its read and write ports and talks to memory through a request/ready handshake. When it has finished it raises `done_o` for one cycle. At that cycle `sp_o` holds the new stack pointer, and `jump_o` / `jump_target_o` tell whether a restore ends in an indirect jump and where it goes.

The controller has seven states:

| State | Role |
|---|---|
| IDLE | waits for a start pulse |
| SAVE | one store per selected register |
| CARVE | subtracts the frame size |
| RELEASE | adds the frame size |
| RESTORE | one load per selected register |
| JUMP | reads the jump register |
| DONE | issues the completion pulse |

Its transitions are:

| From | To | Condition |
|---|---|---|
| IDLE | SAVE | start with save mode |
| IDLE | RELEASE | start with restore mode |
| SAVE | SAVE | while selected registers remain |
| SAVE | CARVE | list exhausted |
| CARVE | DONE | always |
| RELEASE | RESTORE | always |
| RESTORE | RESTORE | while selected registers remain |
| RESTORE | JUMP | list exhausted, jump index nonzero |
| RESTORE | DONE | list exhausted, jump index zero |
| JUMP | DONE | always |
| DONE | IDLE | always |

Top module: `frame_seq`

## Requirements
- R1: After reset the following are all 0: `busy_o`, `done_o`, `mem_req_o`, `rf_we_o`, `jump_o`, `sp_o`.
- R2: The 12-bit selection is `{list_hi_i, list_lo_i}`, so `list_hi_i` is bit 11. Bit i set selects register number 20+i. A cleared bit costs no memory access.
- R3: In save mode (`dispose_i`=0), selected registers are visited in ascending bit order. Each store writes the register's value (read combinationally through `rf_rd_idx_o`/`rf_rd_data_i`) to address SP-4, and SP then becomes SP-4. Lower-numbered registers therefore land at higher addresses.
- R4: In save mode, after all stores, SP is reduced by 4 times `frame_i`. The block performs no memory write other than the stores of R3.
- R5: In restore mode (`dispose_i`=1), SP is first increased by 4 times `frame_i`. The first load address is therefore the start SP plus 4·`frame_i`.
- R6: In restore mode, selected registers are visited in descending bit order. Each load reads the word at SP, writes it into the register through `rf_we_o`/`rf_wr_idx_o`/`rf_wr_data_o`, and SP then becomes SP+4.
- R7: In restore mode with `jump_reg_i` nonzero, `jump_o` is 1 at completion and `jump_target_o` equals that register's value after all loads. With `jump_reg_i` zero, and in save mode, `jump_o` is 0.
- R8: A memory request keeps its address, direction and write data stable until `mem_ready_i` is seen high. SP moves by exactly 4 per completed access.
- R9: Completion is a single-cycle `done_o` pulse, with the final SP on `sp_o`. An empty selection completes with only the SP adjustment and no memory access.
- R10: A `start_i` pulse while `busy_o` is 1 is ignored. The running operation finishes with the results of the first start only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, sampled in IDLE only |
| dispose_i | input | 1 | 0 = save/build frame, 1 = restore/tear down |
| list_hi_i | input | 1 | Selection bit 11 (register r31) |
| list_lo_i | input | 11 | Selection bits 10..0 (registers r30..r20) |
| frame_i | input | 5 | Local frame size in words |
| jump_reg_i | input | 5 | Register index for the ending jump on restore, 0 = none |
| sp_i | input | 32 | Stack pointer at start |
| rf_rd_idx_o | output | 5 | Register-file read index |
| rf_rd_data_i | input | 32 | Register-file read data (combinational) |
| rf_we_o | output | 1 | Register-file write enable |
| rf_wr_idx_o | output | 5 | Register-file write index |
| rf_wr_data_o | output | 32 | Register-file write data |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = store, 0 = load |
| mem_addr_o | output | 32 | Memory word address in bytes |
| mem_wdata_o | output | 32 | Store data |
| mem_rdata_i | input | 32 | Load data, valid with ready |
| mem_ready_i | input | 1 | Access completes when high with request |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sp_o | output | 32 | Current / final stack pointer |
| jump_o | output | 1 | Restore ends in an indirect jump |
| jump_target_o | output | 32 | Jump target |

## Verification
The sequencer is tried with several selections:

- a sparse selection that uses the upper field, which shows whether the two fields are joined in the right order;
- a full twelve-register selection, which shows whether the walk order and the address step are correct;
- empty selections, which separate the frame adjustment from the transfers.

A save followed by a restore of the same frame checks that the descending walk and the early frame release put back exactly what was stored. Restores with a jump index inside and outside the list distinguish a target taken after the loads from one read too early. Ready latencies of 0, 1, 2 and 3 cycles, together with a second start pulse issued mid-run, show whether the handshake is held and whether a busy block ignores new work.

// File: rtl/fs_pkg.sv
package fs_pkg;
    typedef enum logic [2:0] {
        FS_IDLE,
        FS_SAVE,
        FS_CARVE,
        FS_RELEASE,
        FS_RESTORE,
        FS_JUMP,
        FS_DONE
    } fs_state_e;

    localparam int unsigned WORD_BYTES = 4;
endpackage

// File: rtl/fs_pick.sv
// Picks the next set bit of a mask, lowest first or highest first.
module fs_pick #(
    parameter int N       = 12,
    parameter int IW      = 4,
    parameter bit DESCEND = 1'b0
) (
    input  logic [N-1:0]  mask_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    assign any_o = |mask_i;

    generate
        if (DESCEND) begin : g_high
            always_comb begin
                idx_o = '0;
                for (int i = 0; i < N; i++) begin
                    if (mask_i[i]) idx_o = IW'(i);
                end
            end
        end else begin : g_low
            always_comb begin
                idx_o = '0;
                for (int i = N - 1; i >= 0; i--) begin
                    if (mask_i[i]) idx_o = IW'(i);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/fs_frame_adj.sv
// Stack pointer plus / minus the local frame size in bytes.
module fs_frame_adj #(
    parameter int DW = 32,
    parameter int FW = 5
) (
    input  logic [DW-1:0] sp_i,
    input  logic [FW-1:0] words_i,
    output logic [DW-1:0] grow_o,
    output logic [DW-1:0] shrink_o
);
    localparam int SHIFT = $clog2(fs_pkg::WORD_BYTES);

    logic [DW-1:0] bytes;
    assign bytes    = DW'(words_i) << SHIFT;
    assign grow_o   = sp_i + bytes;
    assign shrink_o = sp_i - bytes;
endmodule

// File: rtl/frame_seq.sv
module frame_seq
    import fs_pkg::*;
#(
    parameter int DW       = 32,
    parameter int NREG     = 12,
    parameter int BASE_REG = 20,
    parameter int FW       = 5,
    parameter int RW       = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            dispose_i,
    input  logic            list_hi_i,
    input  logic [NREG-2:0] list_lo_i,
    input  logic [FW-1:0]   frame_i,
    input  logic [RW-1:0]   jump_reg_i,
    input  logic [DW-1:0]   sp_i,
    output logic [RW-1:0]   rf_rd_idx_o,
    input  logic [DW-1:0]   rf_rd_data_i,
    output logic            rf_we_o,
    output logic [RW-1:0]   rf_wr_idx_o,
    output logic [DW-1:0]   rf_wr_data_o,
    output logic            mem_req_o,
    output logic            mem_we_o,
    output logic [DW-1:0]   mem_addr_o,
    output logic [DW-1:0]   mem_wdata_o,
    input  logic [DW-1:0]   mem_rdata_i,
    input  logic            mem_ready_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [DW-1:0]   sp_o,
    output logic            jump_o,
    output logic [DW-1:0]   jump_target_o
);
    localparam int IW = $clog2(NREG);
    localparam logic [DW-1:0] STEP = DW'(WORD_BYTES);

    fs_state_e state_q, state_d;
    logic [NREG-1:0] mask_q;
    logic            dispose_q;
    logic [FW-1:0]   frame_q;
    logic [RW-1:0]   jreg_q;
    logic [DW-1:0]   sp_q, tgt_q;
    logic            jump_q;

    logic          up_any, dn_any, pick_any, xfer;
    logic [IW-1:0] up_idx, dn_idx, pick_idx;
    logic [RW-1:0] pick_reg;
    logic [DW-1:0] sp_grow, sp_shrink;

    fs_pick #(.N(NREG), .IW(IW), .DESCEND(1'b0)) u_pick_up (
        .mask_i(mask_q), .any_o(up_any), .idx_o(up_idx)
    );
    fs_pick #(.N(NREG), .IW(IW), .DESCEND(1'b1)) u_pick_dn (
        .mask_i(mask_q), .any_o(dn_any), .idx_o(dn_idx)
    );
    fs_frame_adj #(.DW(DW), .FW(FW)) u_adj (
        .sp_i(sp_q), .words_i(frame_q), .grow_o(sp_grow), .shrink_o(sp_shrink)
    );

    assign pick_idx = dispose_q ? dn_idx : up_idx;
    assign pick_any = dispose_q ? dn_any : up_any;
    assign pick_reg = RW'(BASE_REG) + RW'(pick_idx);
    assign xfer     = pick_any & mem_ready_i
                    & ((state_q == FS_SAVE) | (state_q == FS_RESTORE));

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE:    if (start_i) state_d = dispose_i ? FS_RELEASE : FS_SAVE;
            FS_SAVE:    if (!pick_any) state_d = FS_CARVE;
            FS_CARVE:   state_d = FS_DONE;
            FS_RELEASE: state_d = FS_RESTORE;
            FS_RESTORE: if (!pick_any) state_d = (jreg_q != '0) ? FS_JUMP : FS_DONE;
            FS_JUMP:    state_d = FS_DONE;
            FS_DONE:    state_d = FS_IDLE;
            default:    state_d = FS_IDLE;
        endcase
    end

    // State register and working registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= FS_IDLE;
            mask_q    <= '0;
            dispose_q <= 1'b0;
            frame_q   <= '0;
            jreg_q    <= '0;
            sp_q      <= '0;
            jump_q    <= 1'b0;
            tgt_q     <= '0;
        end else begin
            state_q <= state_d;
            case (state_q)
                FS_IDLE: if (start_i) begin
                    mask_q    <= {list_hi_i, list_lo_i};
                    dispose_q <= dispose_i;
                    frame_q   <= frame_i;
                    jreg_q    <= jump_reg_i;
                    sp_q      <= sp_i;
                    jump_q    <= 1'b0;
                    tgt_q     <= '0;
                end
                FS_SAVE: if (xfer) begin
                    sp_q             <= sp_q - STEP;
                    mask_q[pick_idx] <= 1'b0;
                end
                FS_RESTORE: if (xfer) begin
                    sp_q             <= sp_q + STEP;
                    mask_q[pick_idx] <= 1'b0;
                end
                FS_CARVE:   sp_q <= sp_shrink;
                FS_RELEASE: sp_q <= sp_grow;
                FS_JUMP: begin
                    jump_q <= 1'b1;
                    tgt_q  <= rf_rd_data_i;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        rf_rd_idx_o  = '0;
        rf_we_o      = 1'b0;
        rf_wr_idx_o  = '0;
        rf_wr_data_o = '0;
        mem_req_o    = 1'b0;
        mem_we_o     = 1'b0;
        mem_addr_o   = '0;
        mem_wdata_o  = '0;
        done_o       = 1'b0;
        unique case (state_q)
            FS_SAVE: begin
                mem_req_o   = pick_any;
                mem_we_o    = 1'b1;
                mem_addr_o  = sp_q - STEP;
                rf_rd_idx_o = pick_reg;
                mem_wdata_o = rf_rd_data_i;
            end
            FS_RESTORE: begin
                mem_req_o    = pick_any;
                mem_addr_o   = sp_q;
                rf_we_o      = xfer;
                rf_wr_idx_o  = pick_reg;
                rf_wr_data_o = mem_rdata_i;
            end
            FS_JUMP: rf_rd_idx_o = jreg_q;
            FS_DONE: done_o = 1'b1;
            default: ;
        endcase
    end

    assign busy_o        = (state_q != FS_IDLE);
    assign sp_o          = sp_q;
    assign jump_o        = jump_q;
    assign jump_target_o = tgt_q;
endmodule

// File: rtl/fs_chk.sv
module fs_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req_o,
    input logic          mem_we_o,
    input logic          mem_ready_i,
    input logic [DW-1:0] mem_addr_o,
    input logic [DW-1:0] mem_wdata_o,
    input logic          rf_we_o,
    input logic          busy_o,
    input logic          done_o,
    input logic [DW-1:0] sp_o
);
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)
                                         && $stable(mem_we_o) && $stable(mem_wdata_o)));

    assert_store_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ready_i && mem_we_o) |=> (sp_o == $past(sp_o) - DW'(4)));

    assert_load_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ready_i && !mem_we_o) |=> (sp_o == $past(sp_o) + DW'(4)));

    assert_load_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> (mem_req_o && mem_ready_i && !mem_we_o));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mem_req_o && !rf_we_o && !done_o));

    assert_run_to_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);
endmodule

bind frame_seq fs_chk #(.DW(DW)) u_fs_chk (
    .clk(clk), .rst_n(rst_n),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_ready_i(mem_ready_i),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .rf_we_o(rf_we_o), .busy_o(busy_o), .done_o(done_o), .sp_o(sp_o)
);

// File: tb/tb_frame_seq.sv
`timescale 1ns/1ps
module tb_frame_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, dispose = 1'b0, lhi = 1'b0;
    logic [10:0] llo = '0;
    logic [4:0]  frame = '0, jreg = '0;
    logic [31:0] sp_in = '0;
    logic [4:0]  rd_idx, wr_idx;
    logic [31:0] rd_data, wr_data, addr, wdata, rdata, sp_out, tgt;
    logic        rf_we, req, we, ready, busy, done, jump;

    always #5 clk = ~clk;

    frame_seq dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .dispose_i(dispose),
        .list_hi_i(lhi), .list_lo_i(llo), .frame_i(frame), .jump_reg_i(jreg),
        .sp_i(sp_in), .rf_rd_idx_o(rd_idx), .rf_rd_data_i(rd_data),
        .rf_we_o(rf_we), .rf_wr_idx_o(wr_idx), .rf_wr_data_o(wr_data),
        .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata),
        .mem_rdata_i(rdata), .mem_ready_i(ready), .busy_o(busy), .done_o(done),
        .sp_o(sp_out), .jump_o(jump), .jump_target_o(tgt)
    );

    // Register file and memory models
    logic [31:0] regs [32];
    logic [31:0] mem [512];
    int lat = 0;
    int wait_cnt = 0;
    int tr_n = 0;
    logic [31:0] tr_addr [16];
    logic        tr_we   [16];
    logic [31:0] tr_data [16];

    assign rd_data = regs[rd_idx];
    assign rdata   = mem[addr[10:2]];
    assign ready   = req && (wait_cnt >= lat);

    always @(posedge clk) begin
        if (!req || ready) wait_cnt <= 0;
        else wait_cnt <= wait_cnt + 1;
        if (rf_we) regs[wr_idx] <= wr_data;
        if (req && ready) begin
            if (we) mem[addr[10:2]] <= wdata;
            if (tr_n < 16) begin
                tr_addr[tr_n] = addr;
                tr_we[tr_n]   = we;
                tr_data[tr_n] = we ? wdata : rdata;
            end
            tr_n = tr_n + 1;
        end
    end

    int checks = 0;
    int errors = 0;
    int dones  = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic launch(input bit d, input logic [11:0] list, input logic [4:0] fr,
                          input logic [4:0] jr, input logic [31:0] sp, input int l);
        @(negedge clk);
        lat = l; tr_n = 0; dones = 0;
        dispose = d; lhi = list[11]; llo = list[10:0]; frame = fr; jreg = jr; sp_in = sp;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (done) dones++;
        chk(done, "R9 completion reached", 32'(done), 32'd1);
    endtask

    task automatic do_save(input logic [11:0] list, input logic [4:0] fr,
                           input logic [31:0] sp, input int l, input string tg);
        logic [31:0] e = sp;
        int k = 0;
        logic [31:0] snap [12];
        for (int i = 0; i < 12; i++) snap[i] = regs[20 + i];
        launch(1'b0, list, fr, 5'd0, sp, l);
        wait_done();
        for (int i = 0; i < 12; i++) begin
            if (list[i]) begin
                e = e - 32'd4;
                chk(tr_addr[k] == e && tr_we[k], {"R3 store address ", tg}, tr_addr[k], e);
                chk(tr_data[k] == snap[i], {"R3 store data ", tg}, tr_data[k], snap[i]);
                k++;
            end
        end
        chk(tr_n == k, {"R2 access count ", tg}, 32'(tr_n), 32'(k));
        e = e - {25'd0, fr, 2'b00};
        chk(sp_out == e, {"R4 final sp ", tg}, sp_out, e);
        chk(!jump, {"R7 no jump on save ", tg}, 32'(jump), 32'd0);
        @(negedge clk);
        chk(!done && !busy, {"R9 single pulse ", tg}, 32'(done), 32'd0);
    endtask

    task automatic do_restore(input logic [11:0] list, input logic [4:0] fr, input logic [4:0] jr,
                              input logic [31:0] sp, input int l, input string tg);
        logic [31:0] e = sp + {25'd0, fr, 2'b00};
        logic [31:0] xr [32];
        int k = 0;
        for (int i = 0; i < 32; i++) xr[i] = regs[i];
        launch(1'b1, list, fr, jr, sp, l);
        wait_done();
        for (int i = 11; i >= 0; i--) begin
            if (list[i]) begin
                chk(tr_addr[k] == e && !tr_we[k], {"R5 R6 load address ", tg}, tr_addr[k], e);
                xr[20 + i] = mem[e[10:2]];
                chk(regs[20 + i] == xr[20 + i], {"R6 restored value ", tg}, regs[20 + i], xr[20 + i]);
                e = e + 32'd4;
                k++;
            end
        end
        chk(tr_n == k, {"R2 access count ", tg}, 32'(tr_n), 32'(k));
        chk(sp_out == e, {"R6 final sp ", tg}, sp_out, e);
        chk(jump == (jr != 0), {"R7 jump flag ", tg}, 32'(jump), 32'(jr != 0));
        if (jr != 0) chk(tgt == xr[jr], {"R7 jump target ", tg}, tgt, xr[jr]);
        @(negedge clk);
        chk(!done && !busy, {"R9 single pulse ", tg}, 32'(done), 32'd0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) regs[i] = 32'hA000_0000 + 32'(i) * 32'h0101;
        for (int i = 0; i < 512; i++) mem[i] = 32'hDEAD_0000 + 32'(i);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !req && !rf_we && !jump && sp_out == 0, "R1 reset state",
            {busy, done, req, rf_we, jump, 27'd0}, 32'd0);
        rst_n = 1'b1;

        // R2 R3 R4: sparse list with upper field, r20 r22 r31
        do_save(12'b1000_0000_0101, 5'd3, 32'h400, 0, "sparse");
        chk(mem[32'h3F4 >> 2] == regs[31], "R3 r31 at lowest address", mem[32'h3F4 >> 2], regs[31]);

        // R5 R6 R7: restore it after scrambling
        regs[20] = 32'h0; regs[22] = 32'h0; regs[31] = 32'h0;
        do_restore(12'b1000_0000_0101, 5'd3, 5'd0, 32'h3E8, 2, "sparse back");
        chk(regs[31] == 32'hA000_0000 + 31 * 32'h0101, "R6 r31 round trip",
            regs[31], 32'hA000_0000 + 31 * 32'h0101);

        // Full list, latency 1, then restore with jump through a listed register
        do_save(12'hFFF, 5'd2, 32'h380, 1, "full");
        for (int i = 20; i < 32; i++) regs[i] = 32'h5555_0000 + 32'(i);
        do_restore(12'hFFF, 5'd2, 5'd31, 32'h380 - 32'd56, 1, "full jump31");

        // Jump through an unlisted register
        do_restore(12'b0000_0001_0000, 5'd1, 5'd5, 32'h300, 3, "jump r5");

        // R9 empty lists
        do_save(12'h000, 5'd7, 32'h300, 0, "empty save");
        do_restore(12'h000, 5'd0, 5'd0, 32'h200, 0, "empty restore");

        // R10 start while busy is ignored
        launch(1'b0, 12'h00F, 5'd1, 5'd0, 32'h380, 3);
        @(negedge clk);
        dispose = 1'b1; sp_in = 32'h100; llo = 11'h7FF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk(sp_out == 32'h36C, "R10 sp of first start only", sp_out, 32'h36C);
        chk(tr_n == 4 && tr_we[0] && tr_we[3], "R10 only first op accesses", 32'(tr_n), 32'd4);
        @(negedge clk);
        chk(!busy && !done, "R10 back to idle after one done", 32'(busy), 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule